// File: doc/BRIEF.md
# Stored-Frame Pixel Array Timing Sequencer

This block generates the digital gate and clock sequence for a pixel array in which every cell keeps its charge samples in a small serial storage register. A single trigger starts a capture phase that matches the bunch train. During capture the sequencer transfers charge from the photogate into storage once per capture period and advances the storage register at that same slow rate. It captures a fixed number of frames and does not convert any charge while the train is running.

Once the last frame is stored, the sequencer enters the quiet period that follows the train and reads the stored samples out at a much faster step rate. It selects one row at a time. All columns of that row are digitised in parallel. For every stored sample, the sequencer resets the sense node, strobes the column converters for the reset level, clocks one charge packet onto the sense node, and strobes the converters again for the signal level.

There is no data stream through this block. The trigger, the depth setting and all outputs are plain level or pulse pins without handshakes. The converted samples leave through the column converters, not through this block. The default parameters describe a 16-row array, a storage depth of 20, a capture period of 2500 cycles (50 µs at 50 MHz) and a readout step of 50 cycles (1 MHz).

Top module: `isis_seq`

## Requirements
- R1: While reset is held and in the first idle cycles after it, every output is low and `row_sel` is all zeros.
- R2: A `trig` pulse sampled while idle starts capture at the next clock edge. Capture consists of D frames of CAP_DIV cycles each. In cycle 0 of every frame `xfer_gate` is high for one cycle. In cycle 1 of every frame `stor_clk` is high for one cycle.
- R3: The frame count D is taken from `cfg_depth` at the accepted trigger. A value of 0 is treated as 1, and any value above MAX_DEPTH is treated as MAX_DEPTH. Changing `cfg_depth` during a run does not alter that run's schedule.
- R4: Readout begins in the cycle after the last capture cycle. `row_sel` is one-hot, with bit i selecting row i. Rows are visited in ascending order from 0, and each row is held for D·4·RD_DIV cycles.
- R5: Within a row, each of the D samples has four phases of RD_DIV cycles each, in this order:
  - Phase 0: `rst_gate` is high for the whole phase.
  - Phase 1: `adc_strobe` pulses for one cycle at the start of the phase, with `adc_sig`=0 (reset level).
  - Phase 2: `stor_clk` pulses for one cycle at the start of the phase.
  - Phase 3: `adc_strobe` pulses for one cycle at the start of the phase, with `adc_sig`=1 (signal level). `adc_sig` stays high throughout phase 3 and is low everywhere else.
- R6: `done` is high for exactly one cycle immediately after the final readout phase, after which the block is idle. `busy` is high from the first capture cycle through the `done` cycle.
- R7: A `trig` sampled while `busy` is high sets `trig_err` for exactly the following cycle and is ignored: the running schedule continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Train-start trigger, sampled each cycle |
| cfg_depth | input | $clog2(MAX_DEPTH+1) | Number of frames to capture and read per cell |
| xfer_gate | output | 1 | Global photogate-to-storage transfer pulse |
| stor_clk | output | 1 | Storage register advance pulse (capture and readout) |
| rst_gate | output | 1 | Sense-node reset gate |
| row_sel | output | ROWS | One-hot row select |
| adc_strobe | output | 1 | Column converter sample strobe |
| adc_sig | output | 1 | 1 while the strobe takes the signal level, 0 for the reset level |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of readout |
| trig_err | output | 1 | One-cycle pulse for a trigger received while busy |

## Verification
The bench runs a small array and sweeps every legal depth. For each depth it predicts every output on every cycle from the frame, row, sample and phase arithmetic.
- Depth 1 and the maximum depth exercise the capture-to-readout boundary and the wrap at the final row. An off-by-one in either would end capture one frame early or late, or skip the last row and assert `done` early.
- Depth values 0 and above the maximum are tested, as is a depth change in the middle of a run. A design that latched or clamped the depth wrongly would shift the entire readout schedule.
- Triggers are injected during capture and during readout. A design that restarted on such a trigger would emit a stray `xfer_gate`, or fail to raise `trig_err` in the following cycle.

// File: rtl/isis_seq_pkg.sv
package isis_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAP  = 2'd1,
    ST_READ = 2'd2,
    ST_DONE = 2'd3
  } seq_state_t;

  // Readout phases of one stored sample, in execution order.
  typedef enum logic [1:0] {
    PH_RST   = 2'd0,
    PH_REF   = 2'd1,
    PH_SHIFT = 2'd2,
    PH_SIG   = 2'd3
  } rd_phase_t;

endpackage

// File: rtl/isis_seq_timer.sv
module isis_seq_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [TW-1:0] limit,
  output logic [TW-1:0] cnt,
  output logic          last
);

  assign last = !clear && (cnt == limit - TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || last)  cnt <= '0;
    else                     cnt <= cnt + TW'(1);
  end

  // Step counter never leaves the period selected by the controller.
  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (cnt < limit));

endmodule

// File: rtl/isis_seq_ctrl.sv
module isis_seq_ctrl
  import isis_seq_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int MAX_DEPTH = 20,
  parameter int CAP_DIV   = 2500,
  parameter int RD_DIV    = 50,
  parameter int DW        = 5,
  parameter int RW        = 5,
  parameter int TW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [DW-1:0] cfg_depth,
  input  logic          tmr_last,
  output logic          tmr_clear,
  output logic [TW-1:0] tmr_limit,
  output seq_state_t    state,
  output rd_phase_t     phase,
  output logic [RW-1:0] row,
  output logic          trig_err
);

  seq_state_t    state_q;
  rd_phase_t     phase_q;
  logic [DW-1:0] depth_q;
  logic [DW-1:0] frame_q;
  logic [DW-1:0] smp_q;
  logic [RW-1:0] row_q;
  logic          err_q;

  function automatic logic [DW-1:0] clamp_depth(input logic [DW-1:0] v);
    if (v == '0)                 return DW'(1);
    else if (v > DW'(MAX_DEPTH)) return DW'(MAX_DEPTH);
    else                         return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_RST;
      depth_q <= DW'(1);
      frame_q <= '0;
      smp_q   <= '0;
      row_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= trig && (state_q != ST_IDLE);
      case (state_q)
        ST_IDLE: begin
          if (trig) begin
            state_q <= ST_CAP;
            depth_q <= clamp_depth(cfg_depth);
            frame_q <= '0;
          end
        end
        ST_CAP: begin
          if (tmr_last) begin
            if (frame_q == depth_q - DW'(1)) begin
              state_q <= ST_READ;
              row_q   <= '0;
              smp_q   <= '0;
              phase_q <= PH_RST;
            end else begin
              frame_q <= frame_q + DW'(1);
            end
          end
        end
        ST_READ: begin
          if (tmr_last) begin
            if (phase_q == PH_SIG) begin
              phase_q <= PH_RST;
              if (smp_q == depth_q - DW'(1)) begin
                smp_q <= '0;
                if (row_q == RW'(ROWS - 1)) state_q <= ST_DONE;
                else                        row_q   <= row_q + RW'(1);
              end else begin
                smp_q <= smp_q + DW'(1);
              end
            end else begin
              phase_q <= rd_phase_t'(phase_q + 2'd1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tmr_clear = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign tmr_limit = (state_q == ST_CAP) ? TW'(CAP_DIV) : TW'(RD_DIV);
  assign state     = state_q;
  assign phase     = phase_q;
  assign row       = row_q;
  assign trig_err  = err_q;

  assert_depth_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> (depth_q >= DW'(1) && depth_q <= DW'(MAX_DEPTH)));

  assert_err_only_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(state_q) != ST_IDLE));

  assert_no_restart_in_readout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && state_q == ST_READ) |=> (state_q != ST_CAP));

  assert_done_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/isis_seq_decode.sv
module isis_seq_decode
  import isis_seq_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int RW   = 5,
  parameter int TW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  seq_state_t      state,
  input  rd_phase_t       phase,
  input  logic [RW-1:0]   row,
  input  logic [TW-1:0]   cnt,
  output logic            xfer_gate,
  output logic            stor_clk,
  output logic            rst_gate,
  output logic [ROWS-1:0] row_sel,
  output logic            adc_strobe,
  output logic            adc_sig,
  output logic            busy,
  output logic            done
);

  logic cap, rd, step0;

  assign cap   = (state == ST_CAP);
  assign rd    = (state == ST_READ);
  assign step0 = (cnt == '0);

  assign xfer_gate  = cap && step0;
  assign stor_clk   = (cap && cnt == TW'(1)) || (rd && phase == PH_SHIFT && step0);
  assign rst_gate   = rd && phase == PH_RST;
  assign adc_strobe = rd && step0 && (phase == PH_REF || phase == PH_SIG);
  assign adc_sig    = rd && phase == PH_SIG;
  assign busy       = (state != ST_IDLE);
  assign done       = (state == ST_DONE);

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign row_sel[i] = rd && (row == RW'(i));
  end

  assert_row_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));

  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |-> (!rst_gate && !xfer_gate && !stor_clk));

  assert_xfer_no_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_gate |-> (row_sel == '0));

endmodule

// File: rtl/isis_seq.sv
module isis_seq
  import isis_seq_pkg::*;
#(
  parameter int ROWS      = 16,
  parameter int MAX_DEPTH = 20,
  parameter int CAP_DIV   = 2500,
  parameter int RD_DIV    = 50,
  localparam int DW       = $clog2(MAX_DEPTH + 1),
  localparam int RW       = $clog2(ROWS + 1),
  localparam int MAXDIV   = (CAP_DIV > RD_DIV) ? CAP_DIV : RD_DIV,
  localparam int TW       = $clog2(MAXDIV + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic [DW-1:0]   cfg_depth,
  output logic            xfer_gate,
  output logic            stor_clk,
  output logic            rst_gate,
  output logic [ROWS-1:0] row_sel,
  output logic            adc_strobe,
  output logic            adc_sig,
  output logic            busy,
  output logic            done,
  output logic            trig_err
);

  initial begin
    assert (CAP_DIV >= 2) else $error("CAP_DIV must be at least 2");
    assert (RD_DIV >= 1)  else $error("RD_DIV must be at least 1");
  end

  seq_state_t    state;
  rd_phase_t     phase;
  logic [RW-1:0] row;
  logic [TW-1:0] cnt, tmr_limit;
  logic          tmr_clear, tmr_last;

  isis_seq_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .limit (tmr_limit),
    .cnt   (cnt),
    .last  (tmr_last)
  );

  isis_seq_ctrl #(
    .ROWS(ROWS), .MAX_DEPTH(MAX_DEPTH), .CAP_DIV(CAP_DIV), .RD_DIV(RD_DIV),
    .DW(DW), .RW(RW), .TW(TW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .cfg_depth (cfg_depth),
    .tmr_last  (tmr_last),
    .tmr_clear (tmr_clear),
    .tmr_limit (tmr_limit),
    .state     (state),
    .phase     (phase),
    .row       (row),
    .trig_err  (trig_err)
  );

  isis_seq_decode #(.ROWS(ROWS), .RW(RW), .TW(TW)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .phase      (phase),
    .row        (row),
    .cnt        (cnt),
    .xfer_gate  (xfer_gate),
    .stor_clk   (stor_clk),
    .rst_gate   (rst_gate),
    .row_sel    (row_sel),
    .adc_strobe (adc_strobe),
    .adc_sig    (adc_sig),
    .busy       (busy),
    .done       (done)
  );

endmodule

// File: tb/isis_seq_tb_top.sv
module isis_seq_tb_top;

  localparam int ROWS      = 3;
  localparam int MAX_DEPTH = 5;
  localparam int CAP_DIV   = 6;
  localparam int RD_DIV    = 2;
  localparam int DW        = $clog2(MAX_DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trig = 1'b0;
  logic [DW-1:0]   cfg_depth = '0;
  logic            xfer_gate, stor_clk, rst_gate, adc_strobe, adc_sig, busy, done, trig_err;
  logic [ROWS-1:0] row_sel;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  isis_seq #(.ROWS(ROWS), .MAX_DEPTH(MAX_DEPTH), .CAP_DIV(CAP_DIV), .RD_DIV(RD_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_depth(cfg_depth),
    .xfer_gate(xfer_gate), .stor_clk(stor_clk), .rst_gate(rst_gate), .row_sel(row_sel),
    .adc_strobe(adc_strobe), .adc_sig(adc_sig), .busy(busy), .done(done), .trig_err(trig_err)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d @%0t", tag, what, act, exp, $time);
    end
  endtask

  // One full run: trigger with cfg_val, expect effective depth d.
  task automatic run(input int cfg_val, input int d, input int inject, input bit cfg_flip,
                     input string rtag);
    int cap_n, row_n, rd_n, total;
    cap_n = d * CAP_DIV;
    row_n = d * 4 * RD_DIV;
    rd_n  = ROWS * row_n;
    total = cap_n + rd_n;
    cfg_depth = DW'(cfg_val);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int c = 0; c <= total + 1; c++) begin
      int e_x, e_s, e_r, e_a, e_g, e_b, e_d, e_e, e_row;
      string t_cap, t_rd, t_end;
      e_x = 0; e_s = 0; e_r = 0; e_a = 0; e_g = 0; e_b = 0; e_d = 0; e_row = 0;
      e_e = (inject >= 0 && c == inject + 1) ? 1 : 0;
      t_cap = (rtag != "") ? rtag : "R2";
      t_rd  = (rtag != "") ? rtag : "R5";
      t_end = (rtag != "") ? rtag : "R6";
      if (c < cap_n) begin
        e_b = 1;
        e_x = (c % CAP_DIV == 0) ? 1 : 0;
        e_s = (c % CAP_DIV == 1) ? 1 : 0;
      end else if (c - cap_n < rd_n) begin
        int dd, rem, ph, k;
        dd  = c - cap_n;
        rem = dd % row_n;
        ph  = (rem / RD_DIV) % 4;
        k   = rem % RD_DIV;
        e_b = 1;
        e_row = 1 << (dd / row_n);
        e_r = (ph == 0) ? 1 : 0;
        e_a = ((ph == 1 || ph == 3) && k == 0) ? 1 : 0;
        e_g = (ph == 3) ? 1 : 0;
        e_s = (ph == 2 && k == 0) ? 1 : 0;
      end else if (c == total) begin
        e_b = 1;
        e_d = 1;
      end
      chk(t_cap, "xfer_gate", int'(xfer_gate), e_x);
      chk(c < cap_n ? t_cap : t_rd, "stor_clk", int'(stor_clk), e_s);
      chk(t_rd, "rst_gate", int'(rst_gate), e_r);
      chk(t_rd, "adc_strobe", int'(adc_strobe), e_a);
      chk(t_rd, "adc_sig", int'(adc_sig), e_g);
      chk((rtag != "") ? rtag : "R4", "row_sel", int'(row_sel), e_row);
      chk(t_end, "busy", int'(busy), e_b);
      chk(t_end, "done", int'(done), e_d);
      chk("R7", "trig_err", int'(trig_err), e_e);
      trig = (c == inject) ? 1'b1 : 1'b0;
      if (cfg_flip && c == 2) cfg_depth = DW'((cfg_val % MAX_DEPTH) + 1);
      @(negedge clk);
    end
    trig = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1", "outputs in reset", int'({xfer_gate, stor_clk, rst_gate, adc_strobe, adc_sig,
        busy, done, trig_err}), 0);
    chk("R1", "row_sel in reset", int'(row_sel), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "outputs idle", int'({xfer_gate, stor_clk, rst_gate, adc_strobe, adc_sig,
        busy, done, trig_err}), 0);
    chk("R1", "row_sel idle", int'(row_sel), 0);
    // Sweep of every legal depth (R2, R4, R5, R6)
    for (int d = 1; d <= MAX_DEPTH; d++) run(d, d, -1, 1'b0, "");
    // R3: clamping and latching of depth
    run(0, 1, -1, 1'b0, "R3");
    run(7, MAX_DEPTH, -1, 1'b0, "R3");
    run(2, 2, -1, 1'b1, "R3");
    // R7: triggers during capture and during readout
    run(2, 2, 3, 1'b0, "");
    run(3, 3, 3 * CAP_DIV + 9, 1'b0, "");
    run(1, 1, 1 * CAP_DIV + ROWS * 4 * RD_DIV - 1, 1'b0, "");
    repeat (3) @(negedge clk);
    chk("R6", "idle after runs", int'(busy), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule